// File: doc/BRIEF.md
# Multichannel Converter Serial Frame Interface

This block is the digital side of an eight-input, 10-bit sampling converter that a host reaches over a four-wire serial link. The host frames each transfer with an active-low select and supplies a serial clock. On the rising clock edges the block collects a control byte that picks the input for the next conversion. On the falling edges it drives a 16-slot output word: zero padding, then the 10-bit result with the MSB first, then more zero padding.

The analog side is outside this block. A model reads the selected channel index from a parallel port and watches the track indicator and the conversion strobe. It hands back a 10-bit result, and the block latches that result at the moment hold begins. While select stays low, conversions run back to back every 16 serial clocks. A power-down flag shows when the converter would be idle.

The serial pins are sampled by a faster system clock `clk`. The block assumes they are already synchronous to that clock. Edges are detected internally, and every output follows a detected edge by one system clock.

Top module: `adc_frame_if`

## Requirements
- R1: While select stays low, a new conversion starts on the falling serial edge that follows every 16th rising edge. At that point track is high and power-down is low again.
- R2: While select is high, `dout_oe` is 0, `dout` is 0 and `track` is 1. Serial clock activity causes no strobe and no state change.
- R3: On falling edges 1 to 4 of a conversion, `dout` is 0. Edges 5 to 14 carry result bits 9 down to 0. Edges 15 and 16 carry 0.
- R4: `din` is sampled on the first 8 rising edges of each conversion, bit 7 first. Byte bits 5:3 form the channel address. Bits 7, 6, 2, 1 and 0 have no effect.
- R5: The address received in one conversion drives `chan_sel` from the start of the next conversion. Address codes 0 to 7 map to channels 0 to 7. After reset `chan_sel` is 0.
- R6: `track` is 1 through falling edge 3. It drops on falling edge 4, and `conv_strobe` pulses for exactly one system clock at the same moment.
- R7: If select falls while the serial clock is low, that select edge counts as falling edge 1 of the conversion.
- R8: `power_down` is 1 while select is high. It is also 1 from falling edge 16 of a conversion until falling edge 1 of the next one. Otherwise it is 0.
- R9: The `result` input is captured when hold begins. Later changes to it do not alter the word being shifted out.
- R10: Raising select mid-conversion clears the edge counters. A partly received control byte is discarded, so `chan_sel` in the next frame keeps the previous complete address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial control data from the host |
| result | input | 10 | Conversion result supplied by the analog model |
| dout | output | 1 | Serial data to the host |
| dout_oe | output | 1 | Output enable for `dout` (1 = driven, 0 = high impedance) |
| chan_sel | output | 3 | Channel being converted |
| track | output | 1 | 1 = tracking the input, 0 = holding and converting |
| conv_strobe | output | 1 | One-clock pulse when hold starts |
| power_down | output | 1 | Converter idle flag |

## Verification
A falling-edge counter that is off by one shifts the result word by one slot in `dout`. It also moves the drop of `track` and the strobe to a different serial edge, so the fault is visible within the same conversion. A wrong shift register or a wrong commit point shows up one conversion later, as an unexpected `chan_sel`. Counters that are not cleared on a mid-frame abort surface in the next frame, as a wrong channel or a misplaced result.

// File: rtl/adcif_pkg.sv
// Shared sizes for the converter serial frame interface.
package adcif_pkg;
    localparam int RES_W      = 10;  // result width
    localparam int ADDR_W     = 3;   // channel address width
    localparam int CTRL_W     = 8;   // control byte length
    localparam int ADDR_LSB   = 3;   // address position in control byte
    localparam int FRAME_LEN  = 16;  // serial clocks per conversion
    localparam int LEAD_ZEROS = 4;   // zero slots ahead of the result
    localparam int HOLD_EDGE  = 4;   // falling edge that starts hold
endpackage

// File: rtl/sif_edge_detect.sv
// Edge detector for the serial pins.
// Turns sclk and cs_n, sampled by clk, into single-cycle event flags.
// Assumes the pins are already synchronous to clk.
// A select fall while sclk is low also counts as a falling edge.
module sif_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic active,
    output logic fe,
    output logic re,
    output logic cs_fall
);
    logic sclk_q;
    logic cs_q;

    // Remember the previous pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    // Qualify the edges with the frame select.
    always_comb begin
        active  = !cs_n;
        cs_fall = active && cs_q;
        fe      = active && ((sclk_q && !sclk) || (cs_fall && !sclk));
        re      = active && !sclk_q && sclk;
    end
endmodule

// File: rtl/sif_ctrl_capture.sv
// Control byte receiver and channel register.
// Shifts din in on the first CTRL_W rising edges of each conversion.
// Keeps the address field as pending, and applies it at the next conversion start.
// Assumes ADDR_LSB >= 1, so the address is complete at the last byte edge.
module sif_ctrl_capture #(
    parameter int CTRL_W    = 8,
    parameter int ADDR_W    = 3,
    parameter int ADDR_LSB  = 3,
    parameter int FRAME_LEN = 16,
    localparam int RCNT_W   = $clog2(FRAME_LEN),
    localparam int SH_W     = ADDR_LSB - 1 + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              re,
    input  logic              cs_fall,
    input  logic              din,
    input  logic              conv_start,
    output logic [ADDR_W-1:0] chan_sel
);
    logic [RCNT_W-1:0] rise_cnt;
    logic [SH_W-1:0]   sh;
    logic [ADDR_W-1:0] pend;

    // Count rising edges within a conversion; clear them when a frame starts or aborts.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || cs_fall) rise_cnt <= '0;
        else if (re)                      rise_cnt <= rise_cnt + 1'b1;
    end

    // Shift control bits in, and commit the address on the last byte edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            pend <= '0;
        end else if (re && active && rise_cnt < RCNT_W'(CTRL_W)) begin
            sh <= {sh[SH_W-2:0], din};
            if (rise_cnt == RCNT_W'(CTRL_W - 1))
                pend <= sh[ADDR_LSB-1 +: ADDR_W];
        end
    end

    // Apply the pending address when a conversion starts.
    always_ff @(posedge clk) begin
        if (!rst_n)          chan_sel <= '0;
        else if (conv_start) chan_sel <= pend;
    end
endmodule

// File: rtl/sif_conv_seq.sv
// Conversion sequencer.
// Counts falling edges within each conversion and drives track, the hold strobe,
// the idle gap flag and the serial output bit. Latches the result at hold.
// Assumes LEAD_ZEROS + RES_W <= FRAME_LEN.
module sif_conv_seq #(
    parameter int RES_W      = 10,
    parameter int FRAME_LEN  = 16,
    parameter int LEAD_ZEROS = 4,
    parameter int HOLD_EDGE  = 4,
    localparam int FCNT_W    = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             fe,
    input  logic             cs_fall,
    input  logic [RES_W-1:0] result,
    output logic             conv_start,
    output logic             out_bit,
    output logic             track,
    output logic             conv_strobe,
    output logic             frame_gap
);
    logic [FCNT_W-1:0] fall_cnt;
    logic [FCNT_W-1:0] fall_nxt;
    logic [RES_W-1:0]  res_q;

    // Pick the output slot value for falling edge k.
    function automatic logic pick_bit(input int k, input logic [RES_W-1:0] r);
        logic [RES_W-1:0] tmp;
        int idx;
        if (k > LEAD_ZEROS && k <= LEAD_ZEROS + RES_W) begin
            idx = LEAD_ZEROS + RES_W - k;
            tmp = r >> idx;
            return tmp[0];
        end
        return 1'b0;
    endfunction

    // Next falling-edge count, and the conversion start condition.
    always_comb begin
        if (cs_fall)                             fall_nxt = fe ? FCNT_W'(1) : '0;
        else if (!fe)                            fall_nxt = fall_cnt;
        else if (fall_cnt == FCNT_W'(FRAME_LEN)) fall_nxt = FCNT_W'(1);
        else                                     fall_nxt = fall_cnt + 1'b1;
        conv_start = cs_fall || (fe && fall_cnt == FCNT_W'(FRAME_LEN));
        frame_gap  = fall_cnt == FCNT_W'(FRAME_LEN);
    end

    // Sequence state: edge count, phase, strobe and serial bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            fall_cnt    <= '0;
            track       <= 1'b1;
            conv_strobe <= 1'b0;
            out_bit     <= 1'b0;
        end else begin
            fall_cnt    <= fall_nxt;
            track       <= fall_nxt < FCNT_W'(HOLD_EDGE);
            conv_strobe <= fe && fall_nxt == FCNT_W'(HOLD_EDGE);
            if (fe) out_bit <= pick_bit(int'(fall_nxt), res_q);
        end
    end

    // Latch the result when hold begins.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        res_q <= '0;
        else if (active && fe && fall_nxt == FCNT_W'(HOLD_EDGE)) res_q <= result;
    end
endmodule

// File: rtl/adc_frame_if.sv
// Top of the converter serial frame interface.
// Connects the edge detector, the control receiver and the sequencer.
// The output enable and the power-down flag follow select directly.
module adc_frame_if
    import adcif_pkg::*;
#(
    parameter int P_RES_W  = RES_W,
    parameter int P_ADDR_W = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                cs_n,
    input  logic                din,
    input  logic [P_RES_W-1:0]  result,
    output logic                dout,
    output logic                dout_oe,
    output logic [P_ADDR_W-1:0] chan_sel,
    output logic                track,
    output logic                conv_strobe,
    output logic                power_down
);
    logic active, fe, re, cs_fall, conv_start, out_bit, frame_gap;

    sif_edge_detect u_edge (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .active(active), .fe(fe), .re(re), .cs_fall(cs_fall)
    );

    sif_ctrl_capture #(
        .CTRL_W(CTRL_W), .ADDR_W(P_ADDR_W), .ADDR_LSB(ADDR_LSB), .FRAME_LEN(FRAME_LEN)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .active(active), .re(re), .cs_fall(cs_fall),
        .din(din), .conv_start(conv_start), .chan_sel(chan_sel)
    );

    sif_conv_seq #(
        .RES_W(P_RES_W), .FRAME_LEN(FRAME_LEN), .LEAD_ZEROS(LEAD_ZEROS), .HOLD_EDGE(HOLD_EDGE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .active(active), .fe(fe), .cs_fall(cs_fall),
        .result(result), .conv_start(conv_start), .out_bit(out_bit), .track(track),
        .conv_strobe(conv_strobe), .frame_gap(frame_gap)
    );

    // Output driver and idle flag.
    always_comb begin
        dout_oe    = active;
        dout       = active && out_bit;
        power_down = !active || frame_gap;
    end
endmodule

// File: rtl/adc_frame_if_chk.sv
// Port-level checks for adc_frame_if, attached with bind.
module adc_frame_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       dout,
    input logic [2:0] chan_sel,
    input logic       track,
    input logic       conv_strobe,
    input logic       power_down
);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && cs_n) |-> (track && !dout));
    // R6
    strobe_at_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> $fell(track));
    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |=> !conv_strobe);
    // R8
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |-> !conv_strobe);
    // R5
    chan_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_sel) |-> $past(!cs_n));
endmodule

bind adc_frame_if adc_frame_if_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout(dout), .chan_sel(chan_sel),
    .track(track), .conv_strobe(conv_strobe), .power_down(power_down)
);

// File: tb/sim_adc_frame_if.sv
module sim_adc_frame_if;
    logic clk = 1'b0;
    logic rst_n, sclk, cs_n, din;
    logic [9:0] result;
    logic dout, dout_oe, track, conv_strobe, power_down;
    logic [2:0] chan_sel;
    int nchk = 0, nfail = 0, strobe_cnt = 0;
    logic [2:0] exp_pend = 3'd0, exp_chan, seen_chan;

    always #2 clk = !clk;

    adc_frame_if u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .result(result),
        .dout(dout), .dout_oe(dout_oe), .chan_sel(chan_sel), .track(track),
        .conv_strobe(conv_strobe), .power_down(power_down)
    );

    always @(posedge clk) if (rst_n && conv_strobe) strobe_cnt <= strobe_cnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half(input logic v);
        @(negedge clk); sclk = v;
        repeat (3) @(negedge clk);
    endtask

    // mode 0: continuing in frame, 1: select falls with sclk high, 2: select falls with sclk low
    task automatic run_conv(input int mode, input logic [7:0] cb, input logic [9:0] res);
        logic [15:0] word;
        int sc0;
        sc0 = strobe_cnt;
        exp_chan = exp_pend;
        result = res;
        for (int i = 1; i <= 16; i++) begin
            if (i == 1 && mode == 2) begin
                @(negedge clk); cs_n = 0; din = cb[7];
                repeat (3) @(negedge clk);
                check(track && dout_oe && !power_down, "R7", {track, dout_oe, power_down}, 3'b110);
            end else begin
                if (i == 1 && mode == 1) begin
                    @(negedge clk); cs_n = 0;
                    repeat (3) @(negedge clk);
                    check(track && !power_down, "R6", {track, power_down}, 2'b10);
                end
                @(negedge clk); sclk = 0;
                if (i <= 8) din = cb[8-i];
                repeat (3) @(negedge clk);
            end
            word[16-i] = dout;
            if (i == 1) check(dout_oe == 1, "R2", dout_oe, 1);
            if (i == 1 && mode == 0) check(track && !power_down, "R1", {track, power_down}, 2'b10);
            if (i == 3) check(track == 1, "R6", track, 1);
            if (i == 4) begin
                check(!track && strobe_cnt == sc0 + 1, "R6", {track, strobe_cnt - sc0}, 1);
                if (mode == 2) check(strobe_cnt == sc0 + 1, "R7", strobe_cnt - sc0, 1);
            end
            if (i == 5) begin
                seen_chan = chan_sel;
                check(chan_sel == exp_chan, "R5", chan_sel, exp_chan);
            end
            if (i == 6) result = ~res;
            if (i == 15) check(power_down == 0, "R8", power_down, 0);
            if (i == 16) check(power_down == 1, "R8", power_down, 1);
            half(1);
            if (i == 16) check(power_down == 1, "R8", power_down, 1);
        end
        check(word == {4'b0, res, 2'b0}, "R3", word, {4'b0, res, 2'b0});
        check(strobe_cnt == sc0 + 1, "R9", strobe_cnt - sc0, 1);
        exp_pend = cb[5:3];
    endtask

    task automatic end_frame();
        @(negedge clk); cs_n = 1;
        repeat (3) @(negedge clk);
        check(!dout_oe && !dout && track, "R2", {dout_oe, dout, track}, 3'b001);
        check(power_down == 1, "R8", power_down, 1);
    endtask

    task automatic idle_toggle();
        int sc0;
        logic [2:0] ch0;
        sc0 = strobe_cnt;
        ch0 = chan_sel;
        for (int k = 0; k < 20; k++) begin half(0); half(1); end
        check(strobe_cnt == sc0 && !dout_oe && chan_sel == ch0, "R2", strobe_cnt - sc0, 0);
    endtask

    task automatic abort_frame(input logic [7:0] cb);
        @(negedge clk); cs_n = 0;
        repeat (3) @(negedge clk);
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk); sclk = 0; din = cb[8-i];
            repeat (3) @(negedge clk);
            if (i == 5) check(chan_sel == exp_pend, "R5", chan_sel, exp_pend);
            half(1);
        end
        end_frame();
        check(track && !dout_oe, "R10", {track, dout_oe}, 2'b10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        rst_n = 0; cs_n = 1; sclk = 1; din = 0; result = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(!dout_oe && power_down && track && !conv_strobe, "R2",
              {dout_oe, power_down, track}, 3'b011);
        check(chan_sel == 0, "R5", chan_sel, 0);

        run_conv(1, 8'b1110_1111, 10'h2B5);     // ignored bits all ones, address 5
        run_conv(0, 8'b0001_1000, 10'h155);     // continuous, address 3
        check(seen_chan == 3'd5, "R4", seen_chan, 5);
        run_conv(0, 8'b0000_0000, 10'h3FF);
        check(seen_chan == 3'd3, "R1", seen_chan, 3);
        end_frame();

        idle_toggle();
        half(0);                                 // sclk low while select is high
        run_conv(2, 8'b0011_1000, 10'h000);      // select edge is the first falling edge
        run_conv(0, 8'b0011_1111, 10'h201);
        check(seen_chan == 3'd7, "R4", seen_chan, 7);
        end_frame();

        abort_frame(8'b0001_0000);               // partial address 2 must be dropped
        run_conv(1, 8'b0000_1000, 10'h001);
        check(seen_chan == 3'd7, "R10", seen_chan, 7);
        end_frame();

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule